// File: doc/BRIEF.md
# Noise-Adaptive Frame Threshold Generator

This block watches one frame of motion-difference pixels and derives from it the global binarisation threshold for the following frame. Columns of the frame are grouped into four vertical strips. For each strip the block gathers an intensity histogram and a pixel sum. Once the last pixel of the frame has arrived, it reads every histogram back in sequence. Each histogram is cut into four equal gray-level sections, and the block takes the dominant gray level of each section. The strip mean is formed by multiplying the strip's pixel sum by a reciprocal held in a configuration input.

A single accumulator combines the per-strip values into a frame threshold. A weighted share of an externally supplied noise variance is added to it. The result is snapped to one of three programmable levels. The published threshold then moves at most one level per frame toward that snapped level. While all of this happens, the same pixel stream is binarised against the threshold currently in force. Histograms are held in two banks, so a new frame may begin on the cycle after the previous one ends.

Top module: `bht_frame_thresh`

## Requirements
- R1: Column c of a line belongs to strip min(floor(c / cfg_blk_w), 3). The rightmost strip therefore takes every column beyond 3·cfg_blk_w. Line length and line count come from cfg_width and cfg_height.
- R2: Each strip histogram is read as four sections of 64 gray levels each: 0–63, 64–127, 128–191 and 192–255. The peak of a section is the level with the highest count. On a tie the lowest such level wins, and a section with no pixels yields its own lowest level. The strip peak sum is the sum of its four section peaks.
- R3: The strip mean is floor(pixel_sum · cfg_recip / 65536).
- R4: The frame threshold is floor(S / 20), where S is the sum over the four strips of (peak sum + strip mean).
- R5: adj_thr reports the frame threshold plus floor(noise_var · 26 / 256), saturated at 65535. noise_var is sampled when the frame result is formed.
- R6: The target level is cfg_lvl_hi when adj_thr ≥ cfg_lvl_hi. Otherwise it is cfg_lvl_mid when adj_thr ≥ cfg_lvl_mid. Otherwise it is cfg_lvl_lo. The three levels are index 0 (lo), 1 (mid) and 2 (hi).
- R7: The level index of thr_out moves one step toward the target index per frame and never jumps two steps. After reset thr_out shows cfg_lvl_lo.
- R8: thr_upd is a single-cycle pulse. It rises 1025 clock edges after the edge that accepts a frame's last pixel, and adj_thr and thr_out take their new values at that same edge.
- R9: One cycle after each accepted pixel, bin_valid is 1 and bin_out is 1 exactly when the pixel exceeded thr_out as it stood when the pixel was accepted. bin_valid is 0 after cycles without a pixel.
- R10: A frame may start on the cycle after the previous frame's last pixel. Every frame's result is then computed from that frame alone, provided each frame lasts more than 1026 cycles.
- R11: thr_out changes only in the cycle where thr_upd is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_width | input | 12 | Pixels per line |
| cfg_height | input | 12 | Lines per frame |
| cfg_blk_w | input | 12 | Columns per strip (last strip takes the remainder) |
| cfg_recip | input | 16 | Reciprocal of strip pixel count, 16 fractional bits |
| cfg_lvl_lo | input | 8 | Lowest quantisation level |
| cfg_lvl_mid | input | 8 | Middle quantisation level |
| cfg_lvl_hi | input | 8 | Highest quantisation level |
| noise_var | input | 16 | Estimated noise variance |
| pix_valid | input | 1 | Difference pixel present this cycle |
| pix_diff | input | 8 | Difference pixel value |
| bin_valid | output | 1 | Binary pixel present |
| bin_out | output | 1 | Binarised pixel |
| thr_out | output | 8 | Threshold in force |
| adj_thr | output | 16 | Noise-adjusted frame threshold of the last frame |
| thr_upd | output | 1 | Pulse when a new frame result is published |

## Verification
A stale or miscounted histogram bin, a wrong section peak or a bad strip sum surfaces only once per frame, as a wrong adj_thr at the thr_upd pulse, about a thousand cycles after the frame's last pixel. That is why each frame's adj_thr is compared against an independent model. Test frames are built so that ties, empty sections and exact level boundaries decide the result. A level-index fault shows in thr_out at the same pulse. It then also shows in bin_out during every pixel of the next frame. A bank mix-up between back-to-back frames shows as one frame's result carrying another frame's counts.

// File: rtl/bht_pkg.sv
// Shared constants for the frame threshold generator.
// Assumes 8-bit pixels, four strips and four histogram sections.
package bht_pkg;
    parameter int PIX_W    = 8;
    parameter int K_BLK    = 4;
    parameter int L_SEC    = 4;
    parameter int CNT_W    = 16;
    parameter int DIM_W    = 12;
    parameter int RECIP_W  = 16;
    parameter int NOISE_W  = 16;
    parameter int ADJ_W    = 16;
    parameter int NOISE_MUL = 26;
    parameter int NOISE_SH  = 8;
    parameter int DIV_SH    = 16;

    localparam int BINS     = 1 << PIX_W;
    localparam int SEC_BINS = BINS / L_SEC;
    localparam int SEC_W    = $clog2(SEC_BINS);
    localparam int BLK_IW   = $clog2(K_BLK);
    localparam int PSUM_W   = CNT_W + PIX_W;
    localparam int PEAK_W   = PIX_W + $clog2(L_SEC) + 1;
    localparam int SUM_W    = PSUM_W + 8;
    localparam int DIVISOR  = K_BLK * L_SEC + K_BLK;
    localparam int DIV_RECIP = ((1 << DIV_SH) + DIVISOR / 2) / DIVISOR;

    typedef enum logic [1:0] {
        LVL_LO  = 2'd0,
        LVL_MID = 2'd1,
        LVL_HI  = 2'd2
    } lvl_e;
endpackage

// File: rtl/bht_hist_bank.sv
// Two banks of per-strip histograms and pixel sums.
// One bank is written by the incoming frame while the other is read out
// and cleared entry by entry. Assumes the caller never points writes and
// clears at the same bank.
module bht_hist_bank
    import bht_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [BLK_IW-1:0] wr_blk,
    input  logic [PIX_W-1:0]  wr_pix,
    input  logic              rd_bank,
    input  logic [BLK_IW-1:0] rd_blk,
    input  logic [PIX_W-1:0]  rd_bin,
    input  logic              rd_clr,
    input  logic              sum_clr,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic [PSUM_W-1:0] rd_psum
);
    logic [CNT_W-1:0]  cnt_q  [2][K_BLK][BINS];
    logic [PSUM_W-1:0] psum_q [2][K_BLK];

    // Count incoming pixels, clear bins and sums as they are consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                for (int k = 0; k < K_BLK; k++) begin
                    psum_q[b][k] <= '0;
                    for (int g = 0; g < BINS; g++) begin
                        cnt_q[b][k][g] <= '0;
                    end
                end
            end
        end else begin
            if (wr_en) begin
                cnt_q[wr_bank][wr_blk][wr_pix] <= cnt_q[wr_bank][wr_blk][wr_pix] + 1'b1;
                psum_q[wr_bank][wr_blk]        <= psum_q[wr_bank][wr_blk] + PSUM_W'(wr_pix);
            end
            if (rd_clr) begin
                cnt_q[rd_bank][rd_blk][rd_bin] <= '0;
            end
            if (sum_clr) begin
                psum_q[rd_bank][rd_blk] <= '0;
            end
        end
    end

    // Present the addressed bin and strip sum of the read bank.
    always_comb begin
        rd_cnt  = cnt_q[rd_bank][rd_blk][rd_bin];
        rd_psum = psum_q[rd_bank][rd_blk];
    end
endmodule

// File: rtl/bht_peak_scan.sv
// Sequential readout of all strip histograms after a frame.
// Tracks the dominant level of each section (lowest level wins ties),
// adds the section peaks and the strip mean, and folds the strip values
// into one frame sum. Takes K_BLK*BINS cycles per frame.
module bht_peak_scan
    import bht_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [RECIP_W-1:0] cfg_recip,
    input  logic [CNT_W-1:0]   rd_cnt,
    input  logic [PSUM_W-1:0]  rd_psum,
    output logic               act,
    output logic [BLK_IW-1:0]  rd_blk,
    output logic [PIX_W-1:0]   rd_bin,
    output logic               blk_end,
    output logic               sum_vld,
    output logic [SUM_W-1:0]   sum_out
);
    logic [CNT_W-1:0]  sec_max_q;
    logic [PIX_W-1:0]  sec_gl_q;
    logic [PEAK_W-1:0] peak_q;
    logic [SUM_W-1:0]  acc_q;

    logic                      sec_first, sec_last, bin_last, take;
    logic [CNT_W-1:0]          cur_max;
    logic [PIX_W-1:0]          cur_gl;
    logic [PEAK_W-1:0]         peak_nx;
    logic [PSUM_W+RECIP_W-1:0] mean_prod;
    logic [PSUM_W-1:0]         mean;
    logic [SUM_W-1:0]          blk_val, acc_nx;

    // Per-bin section tracking and strip / frame sums.
    always_comb begin
        sec_first = (rd_bin[SEC_W-1:0] == '0);
        sec_last  = &rd_bin[SEC_W-1:0];
        bin_last  = &rd_bin;
        take      = sec_first || (rd_cnt > sec_max_q);
        cur_max   = take ? rd_cnt : sec_max_q;
        cur_gl    = take ? rd_bin : sec_gl_q;
        peak_nx   = ((rd_bin == '0) ? '0 : peak_q) + (sec_last ? PEAK_W'(cur_gl) : '0);
        mean_prod = (PSUM_W+RECIP_W)'(rd_psum) * (PSUM_W+RECIP_W)'(cfg_recip);
        mean      = mean_prod[RECIP_W +: PSUM_W];
        blk_val   = SUM_W'(peak_nx) + SUM_W'(mean);
        acc_nx    = ((rd_blk == '0) ? '0 : acc_q) + blk_val;
        blk_end   = act && bin_last;
    end

    // Walk strips and bins from the start pulse to the final bin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act    <= 1'b0;
            rd_blk <= '0;
            rd_bin <= '0;
        end else if (start) begin
            act    <= 1'b1;
            rd_blk <= '0;
            rd_bin <= '0;
        end else if (act) begin
            rd_bin <= rd_bin + 1'b1;
            if (bin_last) begin
                rd_blk <= rd_blk + 1'b1;
                if (rd_blk == BLK_IW'(K_BLK - 1)) begin
                    act <= 1'b0;
                end
            end
        end
    end

    // Hold the running section maximum and the running peak sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_max_q <= '0;
            sec_gl_q  <= '0;
            peak_q    <= '0;
        end else if (act) begin
            sec_max_q <= cur_max;
            sec_gl_q  <= cur_gl;
            peak_q    <= peak_nx;
        end
    end

    // Single frame accumulator, fed one strip value at the end of each strip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            sum_vld <= 1'b0;
            sum_out <= '0;
        end else begin
            sum_vld <= blk_end && (rd_blk == BLK_IW'(K_BLK - 1));
            if (blk_end) begin
                acc_q <= acc_nx;
                if (rd_blk == BLK_IW'(K_BLK - 1)) begin
                    sum_out <= acc_nx;
                end
            end
        end
    end
endmodule

// File: rtl/bht_thr_ctrl.sv
// Turns the frame sum into the published threshold: divides by
// K*L+K through a constant reciprocal, adds the weighted noise variance,
// snaps to three levels by priority and steps the level index by one.
// Assumes cfg_lvl_lo < cfg_lvl_mid < cfg_lvl_hi.
module bht_thr_ctrl
    import bht_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sum_vld,
    input  logic [SUM_W-1:0]   sum_in,
    input  logic [NOISE_W-1:0] noise_var,
    input  logic [PIX_W-1:0]   lvl_lo,
    input  logic [PIX_W-1:0]   lvl_mid,
    input  logic [PIX_W-1:0]   lvl_hi,
    output logic [PIX_W-1:0]   thr_out,
    output logic [ADJ_W-1:0]   adj_thr,
    output logic               thr_upd
);
    localparam int TG_PW = SUM_W + DIV_SH + 1;
    localparam int NZ_PW = NOISE_W + NOISE_SH;
    localparam int TA_W  = SUM_W + 1;

    logic [TG_PW-1:0] tg_prod;
    logic [SUM_W-1:0] tg;
    logic [NZ_PW-1:0] nz_prod;
    logic [NOISE_W-1:0] nz;
    logic [TA_W-1:0]  ta;
    logic [ADJ_W-1:0] adj_sat;
    lvl_e             tgt, idx_q;

    // Division, noise bias, saturation and level priority encoder.
    always_comb begin
        tg_prod = TG_PW'(sum_in) * TG_PW'(DIV_RECIP);
        tg      = tg_prod[DIV_SH +: SUM_W];
        nz_prod = NZ_PW'(noise_var) * NZ_PW'(NOISE_MUL);
        nz      = nz_prod[NOISE_SH +: NOISE_W];
        ta      = TA_W'(tg) + TA_W'(nz);
        adj_sat = (ta > TA_W'({ADJ_W{1'b1}})) ? '1 : ta[ADJ_W-1:0];
        if (ta >= TA_W'(lvl_hi)) begin
            tgt = LVL_HI;
        end else if (ta >= TA_W'(lvl_mid)) begin
            tgt = LVL_MID;
        end else begin
            tgt = LVL_LO;
        end
    end

    // Step the level index toward the target once per frame result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= LVL_LO;
            adj_thr <= '0;
            thr_upd <= 1'b0;
        end else begin
            thr_upd <= sum_vld;
            if (sum_vld) begin
                adj_thr <= adj_sat;
                if (tgt > idx_q) begin
                    idx_q <= lvl_e'(2'(idx_q) + 2'd1);
                end else if (tgt < idx_q) begin
                    idx_q <= lvl_e'(2'(idx_q) - 2'd1);
                end
            end
        end
    end

    // Map the level index to its programmed value.
    always_comb begin
        case (idx_q)
            LVL_HI:  thr_out = lvl_hi;
            LVL_MID: thr_out = lvl_mid;
            default: thr_out = lvl_lo;
        endcase
    end
endmodule

// File: rtl/bht_frame_thresh.sv
// Top of the frame threshold generator. Tracks pixel position within a
// programmable frame, routes pixels to the strip histograms of the write
// bank, starts the readout at frame end and binarises the stream.
// Assumes each frame lasts more than K_BLK*BINS+2 cycles.
module bht_frame_thresh
    import bht_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIM_W-1:0]   cfg_width,
    input  logic [DIM_W-1:0]   cfg_height,
    input  logic [DIM_W-1:0]   cfg_blk_w,
    input  logic [RECIP_W-1:0] cfg_recip,
    input  logic [PIX_W-1:0]   cfg_lvl_lo,
    input  logic [PIX_W-1:0]   cfg_lvl_mid,
    input  logic [PIX_W-1:0]   cfg_lvl_hi,
    input  logic [NOISE_W-1:0] noise_var,
    input  logic               pix_valid,
    input  logic [PIX_W-1:0]   pix_diff,
    output logic               bin_valid,
    output logic               bin_out,
    output logic [PIX_W-1:0]   thr_out,
    output logic [ADJ_W-1:0]   adj_thr,
    output logic               thr_upd
);
    logic [DIM_W-1:0]  col_q, row_q, bcnt_q;
    logic [BLK_IW-1:0] blk_q;
    logic              wr_bank_q;
    logic              frame_last, col_last;
    logic              scan_start, scan_act, blk_end, sum_vld;
    logic [BLK_IW-1:0] rd_blk;
    logic [PIX_W-1:0]  rd_bin;
    logic [CNT_W-1:0]  rd_cnt;
    logic [PSUM_W-1:0] rd_psum;
    logic [SUM_W-1:0]  frame_sum;

    // Frame end detection from the position counters.
    always_comb begin
        col_last   = (col_q == cfg_width - 1'b1);
        frame_last = pix_valid && col_last && (row_q == cfg_height - 1'b1);
        scan_start = frame_last;
    end

    // Position, strip and bank tracking for the incoming stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q     <= '0;
            row_q     <= '0;
            bcnt_q    <= '0;
            blk_q     <= '0;
            wr_bank_q <= 1'b0;
        end else if (pix_valid) begin
            if (col_last) begin
                col_q  <= '0;
                bcnt_q <= '0;
                blk_q  <= '0;
                row_q  <= frame_last ? '0 : row_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
                if ((bcnt_q == cfg_blk_w - 1'b1) && (blk_q != BLK_IW'(K_BLK - 1))) begin
                    bcnt_q <= '0;
                    blk_q  <= blk_q + 1'b1;
                end else begin
                    bcnt_q <= bcnt_q + 1'b1;
                end
            end
            if (frame_last) begin
                wr_bank_q <= ~wr_bank_q;
            end
        end
    end

    // Binarise each pixel against the threshold in force.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_valid <= 1'b0;
            bin_out   <= 1'b0;
        end else begin
            bin_valid <= pix_valid;
            bin_out   <= pix_valid && (pix_diff > thr_out);
        end
    end

    bht_hist_bank u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pix_valid),
        .wr_bank (wr_bank_q),
        .wr_blk  (blk_q),
        .wr_pix  (pix_diff),
        .rd_bank (~wr_bank_q),
        .rd_blk  (rd_blk),
        .rd_bin  (rd_bin),
        .rd_clr  (scan_act),
        .sum_clr (blk_end),
        .rd_cnt  (rd_cnt),
        .rd_psum (rd_psum)
    );

    bht_peak_scan u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (scan_start),
        .cfg_recip (cfg_recip),
        .rd_cnt    (rd_cnt),
        .rd_psum   (rd_psum),
        .act       (scan_act),
        .rd_blk    (rd_blk),
        .rd_bin    (rd_bin),
        .blk_end   (blk_end),
        .sum_vld   (sum_vld),
        .sum_out   (frame_sum)
    );

    bht_thr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sum_vld   (sum_vld),
        .sum_in    (frame_sum),
        .noise_var (noise_var),
        .lvl_lo    (cfg_lvl_lo),
        .lvl_mid   (cfg_lvl_mid),
        .lvl_hi    (cfg_lvl_hi),
        .thr_out   (thr_out),
        .adj_thr   (adj_thr),
        .thr_upd   (thr_upd)
    );
endmodule

// File: rtl/bht_frame_thresh_chk.sv
// Property checker for the frame threshold generator, bound to the top.
// Assumes the levels are held steady while frames are processed.
module bht_frame_thresh_chk
    import bht_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic [PIX_W-1:0] pix_diff,
    input logic             bin_valid,
    input logic             bin_out,
    input logic [PIX_W-1:0] thr_out,
    input logic             thr_upd,
    input logic [PIX_W-1:0] cfg_lvl_lo,
    input logic [PIX_W-1:0] cfg_lvl_hi,
    input logic             scan_start,
    input logic             scan_act
);
    // R9
    bin_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> bin_valid);

    // R9
    bin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !bin_valid);

    // R9
    bin_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> (bin_out == ($past(pix_diff) > $past(thr_out))));

    // R11
    thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_upd |-> $stable(thr_out));

    // R8
    upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_upd |=> !thr_upd);

    // R7
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_upd && ($past(thr_out) == cfg_lvl_lo)) |-> (thr_out != cfg_lvl_hi));

    // R7
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_upd && ($past(thr_out) == cfg_lvl_hi)) |-> (thr_out != cfg_lvl_lo));

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_start |-> !scan_act);
endmodule

bind bht_frame_thresh bht_frame_thresh_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .pix_diff   (pix_diff),
    .bin_valid  (bin_valid),
    .bin_out    (bin_out),
    .thr_out    (thr_out),
    .thr_upd    (thr_upd),
    .cfg_lvl_lo (cfg_lvl_lo),
    .cfg_lvl_hi (cfg_lvl_hi),
    .scan_start (scan_start),
    .scan_act   (scan_act)
);

// File: tb/bht_frame_thresh_tb.sv
module bht_frame_thresh_tb;
    import bht_pkg::*;

    logic clk = 1'b0;
    logic rst_n;
    logic [DIM_W-1:0]   cfg_width, cfg_height, cfg_blk_w;
    logic [RECIP_W-1:0] cfg_recip;
    logic [PIX_W-1:0]   cfg_lvl_lo, cfg_lvl_mid, cfg_lvl_hi;
    logic [NOISE_W-1:0] noise_var;
    logic               pix_valid;
    logic [PIX_W-1:0]   pix_diff;
    logic               bin_valid, bin_out, thr_upd;
    logic [PIX_W-1:0]   thr_out;
    logic [ADJ_W-1:0]   adj_thr;

    always #10 clk = ~clk;

    bht_frame_thresh u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_blk_w(cfg_blk_w), .cfg_recip(cfg_recip), .cfg_lvl_lo(cfg_lvl_lo),
        .cfg_lvl_mid(cfg_lvl_mid), .cfg_lvl_hi(cfg_lvl_hi), .noise_var(noise_var),
        .pix_valid(pix_valid), .pix_diff(pix_diff), .bin_valid(bin_valid),
        .bin_out(bin_out), .thr_out(thr_out), .adj_thr(adj_thr), .thr_upd(thr_upd)
    );

    int n_chk = 0, n_fail = 0;
    int exp_adj[64], exp_thr[64], cap_adj[64], cap_thr[64];
    int n_exp = 0, n_upd = 0, hold_bad = 0, m_idx = 0;
    int lv[3] = '{40, 90, 110};
    int W = 64, H = 24, BW = 16, RCP = 171;
    logic [PIX_W-1:0] last_thr;
    bit mon_on = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Capture every published result and watch thr_out between pulses.
    always @(negedge clk) begin
        if (mon_on) begin
            if (thr_upd) begin
                cap_adj[n_upd] = int'(adj_thr);
                cap_thr[n_upd] = int'(thr_out);
                n_upd++;
            end else if (thr_out !== last_thr) begin
                hold_bad++;
            end
            last_thr = thr_out;
        end
    end

    function automatic int pix_val(int pat, int f, int r, int c);
        case (pat)
            0: return (r * 7 + c * 3 + f * 11) & 255;
            1: return ((r & 3) << 6) | (((c & 1) != 0) ? 10 : 5);
            2: return 200 + (c & 31);
            4: return (c * 4) & 255;
            5: return 100;
            default: return 0;
        endcase
    endfunction

    // Drive one frame, check binarisation, and record the model result.
    task automatic send_frame(input int pat, input int f, input int nv, input string tag);
        int hist[4][256];
        longint psum[4];
        int bin_bad = 0, pv = 0, pt = 0;
        bit have = 0;
        longint s = 0;
        int tg, ta, q, b;
        for (int k = 0; k < 4; k++) begin
            psum[k] = 0;
            for (int g = 0; g < 256; g++) hist[k][g] = 0;
        end
        noise_var = NOISE_W'(nv);
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                int v;
                @(negedge clk);
                if (have && (bin_valid !== 1'b1 || bin_out !== (pv > pt))) bin_bad++;
                v = pix_val(pat, f, r, c);
                pix_valid = 1'b1;
                pix_diff  = PIX_W'(v);
                pv = v;
                pt = int'(thr_out);
                have = 1;
                b = c / BW;
                if (b > 3) b = 3;
                hist[b][v]++;
                psum[b] += v;
            end
        end
        @(negedge clk);
        if (bin_valid !== 1'b1 || bin_out !== (pv > pt)) bin_bad++;
        pix_valid = 1'b0;
        // R9 binarisation against the threshold in force
        check(bin_bad == 0, {"R9 binarised stream ", tag}, bin_bad, 0);
        for (int k = 0; k < 4; k++) begin
            int pk = 0;
            for (int sct = 0; sct < 4; sct++) begin
                int best = sct * 64;
                for (int g = sct * 64; g < sct * 64 + 64; g++)
                    if (hist[k][g] > hist[k][best]) best = g;
                pk += best;
            end
            s += pk + ((psum[k] * RCP) >>> 16);
        end
        tg = int'(s / 20);
        ta = tg + (nv * 26) / 256;
        if (ta > 65535) ta = 65535;
        q = (ta >= lv[2]) ? 2 : (ta >= lv[1]) ? 1 : 0;
        if (q > m_idx) m_idx++;
        else if (q < m_idx) m_idx--;
        exp_adj[n_exp] = ta;
        exp_thr[n_exp] = lv[m_idx];
        n_exp++;
    endtask

    task automatic wait_upd(input int idx);
        int t = 0;
        while (n_upd <= idx && t < 4000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic check_upd(input int idx, input string tag);
        wait_upd(idx);
        check(cap_adj[idx] == exp_adj[idx], {tag, " adjusted threshold"}, cap_adj[idx], exp_adj[idx]);
        check(cap_thr[idx] == exp_thr[idx], {tag, " published threshold"}, cap_thr[idx], exp_thr[idx]);
    endtask

    task automatic t_reset();
        // R7 reset level, R8 no pulse, R9 no output, R5 cleared
        check(thr_out == 8'd40, "R7 reset threshold", int'(thr_out), 40);
        check(thr_upd == 1'b0, "R8 no pulse at reset", int'(thr_upd), 0);
        check(bin_valid == 1'b0, "R9 idle after reset", int'(bin_valid), 0);
        check(adj_thr == '0, "R5 reset adjusted value", int'(adj_thr), 0);
    endtask

    task automatic t_noise_boundary();
        // R4 empty-frame value 76, R5 noise weight, R6 boundary at mid level
        send_frame(3, 0, 0, "zero");
        check_upd(0, "R4 R2 empty sections");
        check(cap_adj[0] == 76, "R4 frame threshold of black frame", cap_adj[0], 76);
        send_frame(3, 1, 137, "zero nv137");
        check_upd(1, "R5 noise below boundary");
        check(cap_thr[1] == 40, "R6 just below mid", cap_thr[1], 40);
        send_frame(3, 2, 138, "zero nv138");
        check_upd(2, "R5 noise at boundary");
        check(cap_thr[2] == 90, "R6 exactly mid", cap_thr[2], 90);
    endtask

    task automatic t_steps();
        send_frame(2, 3, 0, "high");
        check_upd(3, "R6 high target");
        send_frame(3, 4, 0, "zero");
        check_upd(4, "R7 step down");
        send_frame(3, 5, 0, "zero");
        check_upd(5, "R7 step down again");
        send_frame(2, 6, 0, "high from low");
        check_upd(6, "R7 one step limit");
        check(cap_thr[6] == 90, "R7 low to high stops at mid", cap_thr[6], 90);
    endtask

    task automatic t_mean_tie();
        send_frame(5, 7, 0, "uniform");
        check_upd(7, "R3 strip mean");
        check(cap_adj[7] == 104, "R3 uniform frame value", cap_adj[7], 104);
        send_frame(1, 8, 0, "tie");
        check_upd(8, "R2 tie lowest level");
    endtask

    task automatic t_strips();
        BW = 12;
        cfg_blk_w = DIM_W'(12);
        send_frame(4, 9, 0, "strips");
        check_upd(9, "R1 uneven strips");
    endtask

    task automatic t_back_to_back();
        send_frame(0, 10, 300, "b2b a");
        send_frame(0, 11, 300, "b2b b");
        send_frame(0, 12, 300, "b2b c");
        check_upd(10, "R10 first frame");
        check_upd(11, "R10 second frame");
        check_upd(12, "R10 R3 third frame");
    endtask

    task automatic t_latency();
        int cnt = 1;
        send_frame(3, 13, 0, "latency");
        while (thr_upd !== 1'b1 && cnt < 3000) begin
            @(negedge clk);
            cnt++;
        end
        check(cnt == 1026, "R8 result latency", cnt, 1026);
        @(negedge clk);
        check(thr_upd == 1'b0, "R8 single-cycle pulse", int'(thr_upd), 0);
        check_upd(13, "R8 latency frame");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", n_upd, n_exp);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg_width = DIM_W'(W); cfg_height = DIM_W'(H); cfg_blk_w = DIM_W'(BW);
        cfg_recip = RECIP_W'(RCP);
        cfg_lvl_lo = 8'd40; cfg_lvl_mid = 8'd90; cfg_lvl_hi = 8'd110;
        noise_var = '0; pix_valid = 1'b0; pix_diff = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        last_thr = thr_out;
        mon_on = 1;
        t_reset();
        t_noise_boundary();
        t_steps();
        t_mean_tie();
        t_strips();
        t_back_to_back();
        t_latency();
        // R11 threshold changes only with the pulse
        check(hold_bad == 0, "R11 threshold hold", hold_bad, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule